// File: doc/BRIEF.md
# Bootstrap Refresh Guard for a Half-Bridge PWM Path

This block sits between a PWM source and the driver of one half-bridge. It runs on a fast sampling clock and splits time into PWM frames of a fixed number of clock cycles. In each frame it counts how many cycles its own output spends low. The high-side bootstrap capacitor recharges only while the output is low. If a frame ends with too little low time, the guard forces the start of the next frame low for a set recharge window. It does the same when the bootstrap-undervoltage flag is raised at the end of a frame.

Each forced frame is one recharge attempt. If a set number of attempts in a row end with the undervoltage flag still raised, the guard raises a fault for its own half-bridge only and holds that output low. The fault clears at the first frame end where the flag has dropped. While the reset input is low, the output is held low. In bridge-tied mode the guard then also asks for a weak pulldown so the bootstrap capacitor can charge before switching starts. In single-ended mode the pulldown is never requested.

Top module: `bst_refresh_guard`

## Requirements
- R1: With reset released, no fault and no recharge window active, `pwm_out` equals `pwm_in` in the same cycle.
- R2: A frame is FRAME_CYC clock cycles long. The first frame starts in the first cycle after reset is released, and a recharge window always starts in cycle 0 of a frame.
- R3: If a frame ends with `pwm_out` low for fewer than MIN_LOW_CYC cycles, cycles 0 to REFRESH_CYC-1 of the next frame are forced low. A frame with exactly MIN_LOW_CYC low cycles does not trigger this.
- R4: If `bst_uv` is high in the last cycle of a frame, the next frame carries the same forced-low window as in R3.
- R5: A forced frame that ends with `bst_uv` high counts as one failed recharge. When FAIL_LIMIT failures occur in a row, `bst_fault` rises at the start of the next frame. A forced frame that ends with `bst_uv` low resets the count to zero, and frames that were not forced leave the count unchanged.
- R6: While `bst_fault` is high, `pwm_out` is low. `bst_fault` falls at the start of the frame that follows a frame ending with `bst_uv` low.
- R7: While `rst_n` is low, `pwm_out` is low. Releasing reset clears any fault, the failure count and any pending recharge window.
- R8: `pulldown_en` is high exactly when `rst_n` is low and `se_mode` is 0 (bridge-tied). With `se_mode` = 1 it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low reset and hard mute of this half-bridge |
| pwm_in | input | 1 | Incoming PWM, 1 = high side on |
| bst_uv | input | 1 | Bootstrap undervoltage flag, 1 = capacitor low |
| se_mode | input | 1 | Output configuration, 0 = bridge-tied, 1 = single-ended |
| pwm_out | output | 1 | Corrected PWM towards the half-bridge driver |
| pulldown_en | output | 1 | Weak-pulldown request for bootstrap charging |
| bst_fault | output | 1 | Bootstrap fault, shuts down this half-bridge |

## Verification
The assertions check, on every cycle, the invariants that need no history. The output stays low during reset, during a fault and inside a recharge window. The pulldown is never on in single-ended mode. A fault can only rise right after a frame boundary, and a recharge window only opens at frame position zero. The bench's frame scenarios are needed for the parts that depend on counting. These are the exact low-time threshold, the forced window length, the failure run that raises the fault, a run broken by one good recharge, and a fault clearing and then leaving no state behind after a reset.

// File: rtl/bst_pkg.sv
package bst_pkg;

  // Increment that stops at a ceiling.
  function automatic int unsigned sat_inc(int unsigned v, int unsigned ceil_v);
    return (v >= ceil_v) ? ceil_v : v + 1;
  endfunction

  // True when a frame's low time is below the required minimum.
  function automatic logic low_too_short(int unsigned low_total, int unsigned need);
    return low_total < need;
  endfunction

  // True when one more failure reaches the fault limit.
  function automatic logic next_hits_limit(int unsigned fails, int unsigned lim);
    return (fails + 1) >= lim;
  endfunction

endpackage

// File: rtl/bst_frame_timer.sv
module bst_frame_timer #(
  parameter int unsigned FRAME_CYC = 651
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic [$clog2(FRAME_CYC)-1:0]  frame_pos,
  output logic                          frame_last,
  output logic                          frame_first
);
  localparam int unsigned FW = $clog2(FRAME_CYC);
  localparam logic [FW-1:0] LAST_POS = FW'(FRAME_CYC - 1);

  logic [FW-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_q == LAST_POS) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign frame_pos   = pos_q;
  assign frame_last  = (pos_q == LAST_POS);
  assign frame_first = (pos_q == '0);
endmodule

// File: rtl/bst_low_meter.sv
module bst_low_meter #(
  parameter int unsigned MIN_LOW_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic out_low,
  input  logic frame_last,
  output logic short_frame
);
  localparam int unsigned LW = $clog2(MIN_LOW_CYC + 1);

  logic [LW-1:0] low_q;
  logic [LW-1:0] low_total;

  always_comb begin
    if (out_low) begin
      low_total = LW'(bst_pkg::sat_inc(32'(low_q), MIN_LOW_CYC));
    end else begin
      low_total = low_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
    end else if (frame_last) begin
      low_q <= '0;
    end else begin
      low_q <= low_total;
    end
  end

  assign short_frame = frame_last &&
                       bst_pkg::low_too_short(32'(low_total), MIN_LOW_CYC);
endmodule

// File: rtl/bst_recharge_ctl.sv
module bst_recharge_ctl #(
  parameter int unsigned FRAME_CYC   = 651,
  parameter int unsigned REFRESH_CYC = 16,
  parameter int unsigned FAIL_LIMIT  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bst_uv,
  input  logic                          frame_last,
  input  logic                          short_frame,
  input  logic [$clog2(FRAME_CYC)-1:0]  frame_pos,
  output logic                          force_active,
  output logic                          fault
);
  localparam int unsigned CW = $clog2(FAIL_LIMIT + 1);

  logic          force_req_q;
  logic [CW-1:0] fail_q;
  logic          fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_req_q <= 1'b0;
      fail_q      <= '0;
      fault_q     <= 1'b0;
    end else if (frame_last) begin
      force_req_q <= short_frame || bst_uv;
      if (!bst_uv) begin
        fail_q  <= '0;
        fault_q <= 1'b0;
      end else if (force_req_q) begin
        fail_q <= CW'(bst_pkg::sat_inc(32'(fail_q), FAIL_LIMIT));
        if (bst_pkg::next_hits_limit(32'(fail_q), FAIL_LIMIT)) begin
          fault_q <= 1'b1;
        end
      end
    end
  end

  assign force_active = force_req_q && (32'(frame_pos) < REFRESH_CYC);
  assign fault        = fault_q;
endmodule

// File: rtl/bst_refresh_guard.sv
module bst_refresh_guard #(
  parameter int unsigned FRAME_CYC   = 651,
  parameter int unsigned MIN_LOW_CYC = 8,
  parameter int unsigned REFRESH_CYC = 16,
  parameter int unsigned FAIL_LIMIT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic bst_uv,
  input  logic se_mode,
  output logic pwm_out,
  output logic pulldown_en,
  output logic bst_fault
);
  localparam int unsigned FW = $clog2(FRAME_CYC);

  logic [FW-1:0] frame_pos;
  logic          frame_last;
  logic          frame_first;
  logic          short_frame;
  logic          force_active;
  logic          fault;
  logic          out_val;

  bst_frame_timer #(.FRAME_CYC(FRAME_CYC)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_pos  (frame_pos),
    .frame_last (frame_last),
    .frame_first(frame_first)
  );

  bst_low_meter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_meter (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_low    (!out_val),
    .frame_last (frame_last),
    .short_frame(short_frame)
  );

  bst_recharge_ctl #(
    .FRAME_CYC  (FRAME_CYC),
    .REFRESH_CYC(REFRESH_CYC),
    .FAIL_LIMIT (FAIL_LIMIT)
  ) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bst_uv      (bst_uv),
    .frame_last  (frame_last),
    .short_frame (short_frame),
    .frame_pos   (frame_pos),
    .force_active(force_active),
    .fault       (fault)
  );

  assign out_val     = rst_n && !fault && !force_active && pwm_in;
  assign pwm_out     = out_val;
  assign pulldown_en = !rst_n && !se_mode;
  assign bst_fault   = fault;
endmodule

// File: rtl/bst_refresh_guard_chk.sv
module bst_refresh_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic se_mode,
  input logic pwm_out,
  input logic pulldown_en,
  input logic bst_fault,
  input logic force_active,
  input logic frame_last,
  input logic frame_first
);
  p_reset_quiet_r7: assert property (@(posedge clk) !rst_n |-> !pwm_out);

  p_se_no_pulldown_r8: assert property (@(posedge clk) se_mode |-> !pulldown_en);

  p_fault_mutes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bst_fault |-> !pwm_out);

  p_window_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    force_active |-> !pwm_out);

  p_fault_at_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bst_fault) |-> $past(frame_last));

  p_window_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(force_active) |-> frame_first);
endmodule

bind bst_refresh_guard bst_refresh_guard_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .se_mode     (se_mode),
  .pwm_out     (pwm_out),
  .pulldown_en (pulldown_en),
  .bst_fault   (bst_fault),
  .force_active(force_active),
  .frame_last  (frame_last),
  .frame_first (frame_first)
);

// File: tb/sim_bst_refresh_guard.sv
module sim_bst_refresh_guard;
  localparam int F   = 16;
  localparam int MIN = 4;
  localparam int REF = 6;
  localparam int LIM = 3;
  localparam int NV  = 22;

  // {low cycles at end of frame [7:0], uv, frame forced, fault held}
  localparam logic [10:0] VEC [NV] = '{
    {8'd8, 3'b000}, {8'd2, 3'b000}, {8'd0, 3'b010}, {8'd4, 3'b000},
    {8'd3, 3'b000}, {8'd0, 3'b010}, {8'd8, 3'b100}, {8'd8, 3'b110},
    {8'd8, 3'b110}, {8'd8, 3'b110}, {8'd8, 3'b111}, {8'd8, 3'b011},
    {8'd8, 3'b000}, {8'd8, 3'b100}, {8'd8, 3'b110}, {8'd8, 3'b110},
    {8'd8, 3'b010}, {8'd8, 3'b100}, {8'd8, 3'b110}, {8'd8, 3'b110},
    {8'd8, 3'b010}, {8'd8, 3'b000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_in = 1'b1;
  logic bst_uv = 1'b0;
  logic se_mode = 1'b0;
  logic pwm_out, pulldown_en, bst_fault;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bst_refresh_guard #(
    .FRAME_CYC(F), .MIN_LOW_CYC(MIN), .REFRESH_CYC(REF), .FAIL_LIMIT(LIM)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .bst_uv(bst_uv),
    .se_mode(se_mode), .pwm_out(pwm_out), .pulldown_en(pulldown_en),
    .bst_fault(bst_fault)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  // One frame with reset released; checks every cycle.
  task automatic run_frame(input int lowc, input logic uv, input logic frc,
                           input logic flt, input string tag);
    for (int c = 0; c < F; c++) begin
      logic pin;
      logic exp;
      string t;
      @(negedge clk);
      rst_n  = 1'b1;
      pin    = (c >= F - lowc) ? 1'b0 : 1'b1;
      pwm_in = pin;
      bst_uv = uv;
      #1;
      exp = !flt && !(frc && c < REF) && pin;
      t = (frc && c == 0 && !flt) ? "R2" : tag;
      check(pwm_out, exp, t);
      check(bst_fault, flt, flt ? "R5" : "R6");
      check(pulldown_en, 1'b0, "R8");
    end
  endtask

  task automatic hold_reset(input int n, input logic se);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rst_n   = 1'b0;
      se_mode = se;
      pwm_in  = 1'b1;
      #1;
      check(pwm_out, 1'b0, "R7");
      check(pulldown_en, !se, "R8");
    end
    se_mode = 1'b0;
  endtask

  initial begin
    hold_reset(3, 1'b1);
    hold_reset(3, 1'b0);
    for (int k = 0; k < NV; k++) begin
      logic [10:0] v;
      logic prev_uv;
      logic prev_flt;
      string tag;
      v = VEC[k];
      prev_uv  = (k > 0) ? VEC[k-1][2] : 1'b0;
      prev_flt = (k > 0) ? VEC[k-1][0] : 1'b0;
      if (v[0])      tag = prev_flt ? "R6" : "R5";
      else if (v[1]) tag = prev_uv ? "R4" : "R3";
      else           tag = "R1";
      run_frame(int'(v[10:3]), v[2], v[1], v[0], tag);
    end
    // Directed: raise a fault, then reset must clear it (R7)
    run_frame(8, 1'b1, 1'b0, 1'b0, "R4");
    run_frame(8, 1'b1, 1'b1, 1'b0, "R5");
    run_frame(8, 1'b1, 1'b1, 1'b0, "R5");
    run_frame(8, 1'b1, 1'b1, 1'b0, "R5");
    run_frame(8, 1'b1, 1'b1, 1'b1, "R6");
    hold_reset(4, 1'b0);
    run_frame(8, 1'b0, 1'b0, 1'b0, "R7");
    // Directed: one low sample per frame is short, forces next (R3)
    run_frame(1, 1'b0, 1'b0, 1'b0, "R1");
    run_frame(0, 1'b0, 1'b1, 1'b0, "R3");
    run_frame(F, 1'b0, 1'b0, 1'b0, "R1");
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule